// File: doc/BRIEF.md
# Output Driver Impedance Calibration Sequencer

This block keeps a 6-bit output-driver strength code in step with an external analog comparator. A free-running interval timer opens an evaluation window once every fixed number of clock cycles. At each evaluation the block reads the comparator's up/down flag and moves an internal target code one step in that direction. The target code never wraps: it holds at its lowest or highest value. The applied driver code follows the target only on cycles when the output bus is in high impedance, so the strength never changes while data is being driven. A target that cannot be applied yet stays pending until the first idle cycle, and a later evaluation may replace it first.

A strap input selects the fixed minimum-impedance setting. While the strap is high the driver code is forced to its strongest value and the calibration loop is frozen. A settling counter counts idle (non-read) cycles after reset and raises a sticky ready flag once enough of them have passed. All control and status pins are plain level signals. The block carries no data stream, so it has no valid/ready handshake.

Top module: `drive_cal_seq`

## Requirements
- R1: The first evaluation takes place at the 32nd rising clock edge after reset is released, and later evaluations follow every 32 edges.
- R2: At an evaluation the target code rises by one when cmp_up is 1 and falls by one when cmp_up is 0. It never moves by more than one.
- R3: The target code saturates: an up step at 63 leaves it at 63, and a down step at 0 leaves it at 0.
- R4: drv_code takes a new target only at a clock edge where bus_idle is 1 and an evaluation is pending. The earliest such edge is the one after the evaluation. drv_code does not change while bus_idle is 0.
- R5: When several evaluations occur while the bus is busy, the first idle edge applies the most recent target, which may differ from drv_code by more than one step.
- R6: While min_imp_strap is 1, drv_code reads 63 in the same cycle and evaluations are ignored. After the strap falls, drv_code shows the last applied code again.
- R7: cal_ready rises at the edge of the 1024th cycle with bus_idle at 1 since reset (busy cycles are not counted). It then stays at 1 until reset.
- R8: In and right after reset, drv_code is 32 and cal_ready is 0.
- R9: When an evaluation and an idle apply fall on the same edge, drv_code takes the target from before that evaluation, and the new target stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_up | input | 1 | Comparator result: 1 asks for a stronger code, 0 for a weaker one |
| bus_idle | input | 1 | Output bus is in high impedance this cycle (non-read) |
| min_imp_strap | input | 1 | Selects the fixed strongest setting and bypasses calibration |
| drv_code | output | 6 | Driver strength code in use |
| cal_ready | output | 1 | Settling period complete (sticky) |

## Verification
Two functions can fall on the same edge: the periodic evaluation that changes the target, and the deferred apply of an earlier pending target. The bench forces this case by holding the bus busy except on the exact cycle in which the timer reaches its last count. The apply must then carry the older target, and the newer one must stay pending until the next idle edge. A bench reference model tracks the timer, target, pending flag and settling count every cycle. It is driven by random and directed patterns, including multi-evaluation busy stretches and strap toggles.

// File: rtl/drive_cal_pkg.sv
package drive_cal_pkg;
  localparam int unsigned CODE_W = 6;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10
  } step_dir_e;

  function automatic code_t sat_move(input code_t cur, input step_dir_e dir);
    code_t res;
    res = cur;
    case (dir)
      STEP_UP:   if (cur != {CODE_W{1'b1}}) res = cur + code_t'(1);
      STEP_DOWN: if (cur != '0) res = cur - code_t'(1);
      default:   res = cur;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/cal_interval_timer.sv
module cal_interval_timer #(
  parameter int unsigned PERIOD = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic eval_pulse
);
  localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign eval_pulse = (cnt_q == LAST);
endmodule

// File: rtl/cal_step_unit.sv
module cal_step_unit
  import drive_cal_pkg::*;
#(
  parameter int unsigned RESET_CODE = 32
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  eval_en,
  input  logic  cmp_up,
  output code_t target
);
  step_dir_e dir;
  code_t     target_q;

  always_comb begin
    if (!eval_en)    dir = STEP_HOLD;
    else if (cmp_up) dir = STEP_UP;
    else             dir = STEP_DOWN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) target_q <= code_t'(RESET_CODE);
    else        target_q <= sat_move(target_q, dir);
  end

  assign target = target_q;
endmodule

// File: rtl/cal_apply_stage.sv
module cal_apply_stage
  import drive_cal_pkg::*;
#(
  parameter int unsigned RESET_CODE = 32
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  eval_en,
  input  logic  bus_idle,
  input  logic  freeze,
  input  code_t target,
  output code_t drv_q,
  output logic  pending
);
  logic  pend_q;
  code_t drv_r;
  logic  do_apply;

  assign do_apply = pend_q && bus_idle && !freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_r  <= code_t'(RESET_CODE);
      pend_q <= 1'b0;
    end else begin
      if (do_apply) drv_r <= target;
      if (eval_en)       pend_q <= 1'b1;
      else if (do_apply) pend_q <= 1'b0;
    end
  end

  assign drv_q   = drv_r;
  assign pending = pend_q;
endmodule

// File: rtl/cal_settle_counter.sv
module cal_settle_counter #(
  parameter int unsigned SETTLE = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  output logic ready
);
  localparam int unsigned SW = $clog2(SETTLE + 1);
  localparam logic [SW-1:0] LAST = SW'(SETTLE - 1);

  logic [SW-1:0] cnt_q;
  logic          rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (idle && !rdy_q) begin
      cnt_q <= cnt_q + SW'(1);
      if (cnt_q == LAST) rdy_q <= 1'b1;
    end
  end

  assign ready = rdy_q;
endmodule

// File: rtl/drive_cal_seq.sv
module drive_cal_seq
  import drive_cal_pkg::*;
#(
  parameter int unsigned EVAL_PERIOD = 32,
  parameter int unsigned SETTLE_CYC  = 1024,
  parameter int unsigned RESET_CODE  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_up,
  input  logic              bus_idle,
  input  logic              min_imp_strap,
  output logic [CODE_W-1:0] drv_code,
  output logic              cal_ready
);
  logic  eval_pulse;
  logic  eval_acc;
  code_t target_code;
  code_t drv_reg;
  logic  pend;

  cal_interval_timer #(.PERIOD(EVAL_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .eval_pulse(eval_pulse)
  );

  assign eval_acc = eval_pulse && !min_imp_strap;

  cal_step_unit #(.RESET_CODE(RESET_CODE)) u_step (
    .clk(clk), .rst_n(rst_n), .eval_en(eval_acc), .cmp_up(cmp_up),
    .target(target_code)
  );

  cal_apply_stage #(.RESET_CODE(RESET_CODE)) u_apply (
    .clk(clk), .rst_n(rst_n), .eval_en(eval_acc), .bus_idle(bus_idle),
    .freeze(min_imp_strap), .target(target_code), .drv_q(drv_reg),
    .pending(pend)
  );

  cal_settle_counter #(.SETTLE(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .idle(bus_idle), .ready(cal_ready)
  );

  assign drv_code = min_imp_strap ? {CODE_W{1'b1}} : drv_reg;
endmodule

// File: rtl/drive_cal_seq_chk.sv
module drive_cal_seq_chk
  import drive_cal_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  eval_pulse,
  input logic  strap,
  input logic  bus_idle,
  input logic  cmp_up,
  input code_t target,
  input code_t drv_reg,
  input code_t drv_code,
  input logic  ready
);
  // R2: target moves at most one step per cycle
  p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (target == $past(target)) || (target == $past(target) + code_t'(1)) ||
    (target == $past(target) - code_t'(1)));

  // R1: target only moves right after a timer evaluation
  p_eval_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_pulse |=> $stable(target));

  // R3: upper saturation
  p_sat_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_pulse && cmp_up && (target == {CODE_W{1'b1}})) |=> (target == {CODE_W{1'b1}}));

  // R4: applied code frozen while bus busy
  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_idle |=> $stable(drv_reg));

  // R6: strap forces strongest code and freezes target
  p_strap_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strap |-> (drv_code == {CODE_W{1'b1}}));
  p_strap_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strap |=> $stable(target));

  // R7: ready is sticky
  p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
endmodule

bind drive_cal_seq drive_cal_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eval_pulse(eval_pulse), .strap(min_imp_strap),
  .bus_idle(bus_idle), .cmp_up(cmp_up), .target(target_code),
  .drv_reg(drv_reg), .drv_code(drv_code), .ready(cal_ready)
);

// File: tb/tb_drive_cal_seq.sv
module tb_drive_cal_seq;
  localparam int PER = 32;
  localparam int SET = 1024;
  localparam int RCODE = 32;
  localparam int MAXC = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_up = 1'b0;
  logic bus_idle = 1'b0;
  logic strap = 1'b0;
  logic [5:0] drv_code;
  logic cal_ready;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_tcnt, m_target, m_pend, m_drv, m_icnt, m_ready;

  drive_cal_seq dut (
    .clk(clk), .rst_n(rst_n), .cmp_up(cmp_up), .bus_idle(bus_idle),
    .min_imp_strap(strap), .drv_code(drv_code), .cal_ready(cal_ready)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_tcnt = 0; m_target = RCODE; m_pend = 0; m_drv = RCODE;
    m_icnt = 0; m_ready = 0;
  endtask

  // One rising edge of the reference model, inputs as currently driven
  task automatic model_edge(input bit up, input bit idle, input bit st);
    bit ev;
    bit app;
    int nt;
    ev  = (m_tcnt == PER - 1) && !st;
    app = (m_pend != 0) && idle && !st;
    nt  = m_target;
    if (ev) begin
      if (up && m_target < MAXC) nt = m_target + 1;
      if (!up && m_target > 0)   nt = m_target - 1;
    end
    if (app) m_drv = m_target;
    if (ev) m_pend = 1;
    else if (app) m_pend = 0;
    m_target = nt;
    m_tcnt = (m_tcnt == PER - 1) ? 0 : m_tcnt + 1;
    if (idle && !m_ready) begin
      if (m_icnt == SET - 1) m_ready = 1;
      m_icnt++;
    end
  endtask

  task automatic cyc(input bit up, input bit idle, input bit st, input string tag);
    cmp_up = up; bus_idle = idle; strap = st;
    @(posedge clk);
    model_edge(up, idle, st);
    @(negedge clk);
    chk(tag, int'(drv_code), st ? MAXC : m_drv);
    chk("R7 ready", int'(cal_ready), m_ready);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmp_up = 0; bus_idle = 0; strap = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    model_reset();
    chk("R8 reset code", int'(drv_code), RCODE);
    chk("R8 reset ready", int'(cal_ready), 0);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    @(negedge clk);
    do_reset();

    // R1: first evaluation at edge 32, applied at edge 33
    for (int i = 0; i < 33; i++) cyc(1'b1, 1'b1, 1'b0, "R1 first eval");
    chk("R1 code after first apply", int'(drv_code), RCODE + 1);

    // R2/R3: climb to saturation at 63
    for (int i = 0; i < 1100; i++) cyc(1'b1, 1'b1, 1'b0, "R3 up saturate");
    chk("R3 top", int'(drv_code), MAXC);
    // descend to saturation at 0
    for (int i = 0; i < 2100; i++) cyc(1'b0, 1'b1, 1'b0, "R2 R3 down saturate");
    chk("R3 bottom", int'(drv_code), 0);

    // R5: two evaluations during a busy stretch, then idle
    for (int i = 0; i < 70; i++) cyc(1'b1, 1'b0, 1'b0, "R5 busy");
    for (int i = 0; i < 4; i++)  cyc(1'b1, 1'b1, 1'b0, "R5 apply latest");

    // R9: idle only on the evaluation edge
    for (int i = 0; i < 130; i++) begin
      bit idl;
      idl = (m_tcnt == PER - 1);
      cyc(1'b1, idl, 1'b0, "R9 eval with apply");
    end

    // R6: strap forces strongest code and freezes calibration
    for (int i = 0; i < 80; i++)
      cyc(1'($urandom % 2), 1'($urandom % 2), 1'b1, "R6 strap on");
    for (int i = 0; i < 10; i++)
      cyc(1'($urandom % 2), 1'b0, 1'b0, "R6 strap off");

    // R4: random mix with sparse idle cycles
    for (int i = 0; i < 1500; i++)
      cyc(1'($urandom % 2), ($urandom % 10) < 3, ($urandom % 50) == 0, "R4 random");

    // R7: fresh settling with busy cycles mixed in
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 2600; i++)
      cyc(($urandom % 4) != 0, 1'($urandom % 2), 1'b0, "R4 R7 random settle");
    chk("R7 ready final", int'(cal_ready), 1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule